// File: doc/BRIEF.md
# Expansion-Factor Coefficient Reconstruction

This block turns one transform coefficient, held as four signed integer components in an exact algebraic-integer encoding, into a single signed fixed-point word. The irrational basis values are replaced by small integers, each scaled by a common expansion factor. The first component is multiplied by that factor, and the factor itself is built from a short signed sum of powers of two. The other three components are multiplied by integer weights through shared shift-and-add subexpressions. No general multiplier is used anywhere.

The result is deliberately left multiplied by the expansion factor. The division by that factor belongs to the quantiser that follows. A parameter selects one of two constant sets: a small set that gives a cheap datapath, and a large set that gives a more accurate one. The block takes one coefficient per clock, qualified by a valid strobe, and returns the result two cycles later.

Top module: `airec_reconstruct`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is 0 and `out_data` is 0 after that edge, whatever `in_valid` carries.
- R2: With `CSET` = 0 (small set), a valid result equals 2353·Ya + 512·(12·Yb + 5·Yc + 13·Yd). This is the factor 2^2+2^-1+2^-4+2^-5+2^-9 applied to Ya, with 9 fractional bits, plus the integer weights aligned to the same binary point. The result is exact, with no rounding.
- R3: With `CSET` = 1 (large set), a valid result equals 85622·Ya + 512·(437·Yb + 181·Yc + 473·Yd). This is the factor 2^7+2^5+2^3−2^0+2^-2−2^-6−2^-8 applied to Ya, with 9 fractional bits. The result is exact.
- R4: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and `out_data` carries the result of the inputs sampled with that strobe.
- R5: Inputs sampled while `in_valid` is 0 have no effect: `out_data` keeps the last valid result until the next valid result arrives.
- R6: `out_data` is W+20 bits wide, two's complement with 9 fractional bits. Every combination of full-scale inputs (−2^(W−1) and 2^(W−1)−1 on each component) gives the exact value without wrap-around.
- R7: Valid inputs on consecutive cycles give valid results on consecutive cycles, one per clock, with none lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the four components this cycle |
| in_ya | input | W | Component scaled by the expansion factor, signed |
| in_yb | input | W | Component with first integer weight, signed |
| in_yc | input | W | Component with second integer weight, signed |
| in_yd | input | W | Component with third integer weight, signed |
| out_valid | output | 1 | Result present on `out_data` this cycle |
| out_data | output | W+20 | Expansion-scaled result, signed, 9 fractional bits |

## Verification
The datapath has no feedback, so each fault shows up in the result of the very coefficient that passes through it, exactly two cycles after that coefficient enters. A wrong shift term or subexpression appears as a value offset that grows with one particular component. Driving unit and full-scale vectors makes it plain which weight is wrong. A wrong stage enable shows up instead as a result that changes during a gap in `in_valid`, or as a strobe that arrives one cycle early or late. Comparing every cycle against a model of the intended timing catches it at the first affected edge.

// File: rtl/airec_pkg.sv
package airec_pkg;

    // Binary point of the expansion-scaled result.
    localparam int FRAC_BITS = 9;

    // Constant-set selectors.
    localparam int SET_SMALL = 0;
    localparam int SET_LARGE = 1;

    // Growth of each partial term over the input width.
    localparam int ALPHA_GROW = 18;
    localparam int INT_GROW   = 12;
    localparam int OUT_GROW   = 20;

    // Expansion factor expressed in units of 2^-FRAC_BITS.
    function automatic int alpha_scaled(input int cset);
        return (cset == SET_LARGE) ? 85622 : 2353;
    endfunction

    // Sum of the three integer weights of a set.
    function automatic int weight_sum(input int cset);
        return (cset == SET_LARGE) ? (437 + 181 + 473) : (12 + 5 + 13);
    endfunction

endpackage

// File: rtl/airec_alpha_mul.sv
module airec_alpha_mul
    import airec_pkg::*;
#(
    parameter int W    = 16,
    parameter int CSET = SET_SMALL
) (
    input  logic signed [W-1:0]            y,
    output logic signed [W+ALPHA_GROW-1:0] term
);
    localparam int AW = W + ALPHA_GROW;

    logic signed [AW-1:0] ext;
    assign ext = AW'(y);

    // Signed-digit recoding of the factor, shifted to FRAC_BITS fractional bits.
    if (CSET == SET_LARGE) begin : g_large
        assign term = (ext <<< (FRAC_BITS + 7)) + (ext <<< (FRAC_BITS + 5))
                    + (ext <<< (FRAC_BITS + 3)) - (ext <<< FRAC_BITS)
                    + (ext <<< (FRAC_BITS - 2)) - (ext <<< (FRAC_BITS - 6))
                    - (ext <<< (FRAC_BITS - 8));
    end else begin : g_small
        assign term = (ext <<< (FRAC_BITS + 2)) + (ext <<< (FRAC_BITS - 1))
                    + (ext <<< (FRAC_BITS - 4)) + (ext <<< (FRAC_BITS - 5))
                    + (ext <<< (FRAC_BITS - 9));
    end

    // A positive factor must keep the sign of its operand (R2, R3).
    always_comb begin
        if (y == '0) begin
            a_r2_alpha_zero: assert (term == '0);
        end else begin
            a_r3_alpha_sign: assert (term[AW-1] == y[W-1]);
        end
    end

endmodule

// File: rtl/airec_int_cse.sv
module airec_int_cse
    import airec_pkg::*;
#(
    parameter int W    = 16,
    parameter int CSET = SET_SMALL
) (
    input  logic signed [W-1:0]          yb,
    input  logic signed [W-1:0]          yc,
    input  logic signed [W-1:0]          yd,
    output logic signed [W+INT_GROW-1:0] term
);
    localparam int IW = W + INT_GROW;

    logic signed [IW-1:0] bx, cx, dx;
    assign bx = IW'(yb);
    assign cx = IW'(yc);
    assign dx = IW'(yd);

    if (CSET == SET_LARGE) begin : g_large
        // 473*(b+c+d) - 36*(b+c) - 256*c
        logic signed [IW-1:0] s_bc, s_bcd, p473, p36;
        assign s_bc  = bx + cx;
        assign s_bcd = s_bc + dx;
        assign p473  = (s_bcd <<< 8) + (s_bcd <<< 7) + (s_bcd <<< 6)
                     + (s_bcd <<< 4) + (s_bcd <<< 3) + s_bcd;
        assign p36   = (s_bc <<< 5) + (s_bc <<< 2);
        assign term  = p473 - p36 - (cx <<< 8);
    end else begin : g_small
        // 8*(b+d) + 4*(b+c+d) + d + c
        logic signed [IW-1:0] s_bd, s_bcd;
        assign s_bd  = bx + dx;
        assign s_bcd = s_bd + cx;
        assign term  = (s_bd <<< 3) + (s_bcd <<< 2) + dx + cx;
    end

    // Equal components must be scaled by the total of the weights (R2, R3).
    always_comb begin
        if ((yb == yc) && (yc == yd)) begin
            a_r2_equal_weights: assert (term == (IW'(weight_sum(CSET)) * bx));
        end
    end

endmodule

// File: rtl/airec_join.sv
module airec_join
    import airec_pkg::*;
#(
    parameter int AW = 34,
    parameter int IW = 28,
    parameter int OW = 36
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [AW-1:0] a_term,
    input  logic signed [IW-1:0] i_term,
    output logic signed [OW-1:0] sum_q
);
    logic signed [OW-1:0] a_ext, i_ext;
    assign a_ext = OW'(a_term);
    assign i_ext = OW'(i_term) <<< FRAC_BITS;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (en) begin
            sum_q <= a_ext + i_ext;
        end
    end

    // The result register only moves when the previous stage offers data (R5).
    a_r5_sum_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sum_q));

endmodule

// File: rtl/airec_reconstruct.sv
module airec_reconstruct
    import airec_pkg::*;
#(
    parameter int W    = 16,
    parameter int CSET = SET_SMALL
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [W-1:0]    in_ya,
    input  logic signed [W-1:0]    in_yb,
    input  logic signed [W-1:0]    in_yc,
    input  logic signed [W-1:0]    in_yd,
    output logic                   out_valid,
    output logic signed [W+19:0]   out_data
);
    localparam int AW = W + ALPHA_GROW;
    localparam int IW = W + INT_GROW;
    localparam int OW = W + OUT_GROW;

    typedef struct packed {
        logic signed [AW-1:0] a_term;
        logic signed [IW-1:0] i_term;
    } stage1_t;

    stage1_t s1_next, s1_q;
    logic    s1_valid;

    airec_alpha_mul #(.W(W), .CSET(CSET)) u_alpha (
        .y    (in_ya),
        .term (s1_next.a_term)
    );

    airec_int_cse #(.W(W), .CSET(CSET)) u_cse (
        .yb   (in_yb),
        .yc   (in_yc),
        .yd   (in_yd),
        .term (s1_next.i_term)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= '0;
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_q <= s1_next;
            end
        end
    end

    airec_join #(.AW(AW), .IW(IW), .OW(OW)) u_join (
        .clk    (clk),
        .rst    (rst),
        .en     (s1_valid),
        .a_term (s1_q.a_term),
        .i_term (s1_q.i_term),
        .sum_q  (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_valid;
        end
    end

    a_r4_strobe_forward: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);
    a_r4_strobe_idle: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);
    a_r5_stage1_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(s1_q));
    a_r7_stream: assert property (@(posedge clk) disable iff (rst)
        (in_valid && s1_valid) |=> (s1_valid && out_valid));

endmodule

// File: tb/airec_reconstruct_bench.sv
module airec_reconstruct_bench;

    localparam int W  = 16;
    localparam int OW = W + 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [W-1:0] ya = '0, yb = '0, yc = '0, yd = '0;
    logic                out_valid_a, out_valid_b;
    logic signed [OW-1:0] out_a, out_b;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string phase    = "R1 reset";

    always #5 clk = ~clk;

    airec_reconstruct #(.W(W), .CSET(0)) u_airec_reconstruct (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_ya(ya), .in_yb(yb), .in_yc(yc), .in_yd(yd),
        .out_valid(out_valid_a), .out_data(out_a)
    );

    airec_reconstruct #(.W(W), .CSET(1)) u_airec_reconstruct_b (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_ya(ya), .in_yb(yb), .in_yc(yc), .in_yd(yd),
        .out_valid(out_valid_b), .out_data(out_b)
    );

    function automatic longint ref_small(longint a, longint b, longint c, longint d);
        return 2353 * a + 512 * (12 * b + 5 * c + 13 * d);
    endfunction

    function automatic longint ref_large(longint a, longint b, longint c, longint d);
        return 85622 * a + 512 * (437 * b + 181 * c + 473 * d);
    endfunction

    // Behavioural timing model: two-cycle delay, values held across gaps.
    bit     m1_v, mo_v;
    longint m1_a, m1_b, mo_a, mo_b;
    always @(posedge clk) begin
        if (rst) begin
            m1_v <= 0; mo_v <= 0; m1_a <= 0; m1_b <= 0; mo_a <= 0; mo_b <= 0;
        end else begin
            if (in_valid) begin
                m1_a <= ref_small(longint'(ya), longint'(yb), longint'(yc), longint'(yd));
                m1_b <= ref_large(longint'(ya), longint'(yb), longint'(yc), longint'(yd));
            end
            m1_v <= in_valid;
            if (m1_v) begin
                mo_a <= m1_a;
                mo_b <= m1_b;
            end
            mo_v <= m1_v;
        end
    end

    task automatic check(string req, longint got, longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s [%s]: got %0d expected %0d", req, phase, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !rst) begin
            check("R4 valid set0", longint'(out_valid_a), longint'(mo_v));
            check("R4 valid set1", longint'(out_valid_b), longint'(mo_v));
            check("R2 data set0", longint'(out_a), mo_a);
            check("R3 data set1", longint'(out_b), mo_b);
        end
    end

    task automatic drive(bit v, int a, int b, int c, int d);
        @(negedge clk);
        in_valid = v;
        ya = W'(a); yb = W'(b); yc = W'(c); yd = W'(d);
    endtask

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    initial begin
        // R1: reset clears outputs even with valid data present
        drive(1, 1000, -7, 300, 22);
        repeat (3) @(negedge clk);
        check("R1 reset valid", longint'(out_valid_a | out_valid_b), 0);
        check("R1 reset data0", longint'(out_a), 0);
        check("R1 reset data1", longint'(out_b), 0);
        @(negedge clk);
        in_valid = 0;
        rst = 0;
        checking = 1'b1;

        // R2/R3: unit vectors on each component
        phase = "R2 R3 unit";
        drive(1, 1, 0, 0, 0);  drive(0, 0, 0, 0, 0);
        drive(1, 0, 1, 0, 0);  drive(0, 0, 0, 0, 0);
        drive(1, 0, 0, 1, 0);  drive(0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 1);  drive(0, 0, 0, 0, 0);
        drive(1, -3, 5, -9, 11); drive(0, 0, 0, 0, 0);

        // R4: explicit latency of a lone pulse
        phase = "R4 latency";
        repeat (3) drive(0, 0, 0, 0, 0);
        drive(1, 77, 1, 2, 3);
        drive(0, 0, 0, 0, 0);
        check("R4 not yet", longint'(out_valid_a), 0);
        @(negedge clk);
        check("R4 arrives", longint'(out_valid_a), 1);
        check("R4 value", longint'(out_a), ref_small(77, 1, 2, 3));
        check("R3 value", longint'(out_b), ref_large(77, 1, 2, 3));

        // R6: every full-scale combination
        phase = "R6 extremes";
        for (int k = 0; k < 16; k++) begin
            drive(1, k[0] ? 32767 : -32768, k[1] ? 32767 : -32768,
                     k[2] ? 32767 : -32768, k[3] ? 32767 : -32768);
        end
        drive(0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        check("R6 last extreme", longint'(out_b), ref_large(32767, 32767, 32767, 32767));

        // R7: long back-to-back stream
        phase = "R7 stream";
        for (int k = 0; k < 400; k++) drive(1, rnd16(), rnd16(), rnd16(), rnd16());

        // R5: gaps with junk data on the inputs
        phase = "R5 gaps";
        for (int k = 0; k < 600; k++) begin
            drive(bit'($urandom_range(0, 1)), rnd16(), rnd16(), rnd16(), rnd16());
        end
        drive(1, 123, -456, 789, -1011);
        for (int k = 0; k < 4; k++) drive(0, rnd16(), rnd16(), rnd16(), rnd16());
        check("R5 held set0", longint'(out_a), ref_small(123, -456, 789, -1011));
        check("R5 held set1", longint'(out_b), ref_large(123, -456, 789, -1011));

        repeat (3) @(negedge clk);
        checking = 1'b0;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule